// File: doc/BRIEF.md
# Fence Counter Sync Gate

This block keeps a running count of lower-level cache misses that have gone out and not yet been answered, and uses that count to serve a sync instruction. Every miss sent raises the count by one and every reply received lowers it by one. When the decoder signals a sync, the block raises an issue-stall output. That output stays high until the miss count is zero and the core reports that every outstanding memory operation has committed.

The count saturates at its parameterised maximum. A miss that arrives when the count is already at that maximum is not counted and sets a sticky overflow flag. A reply that arrives at a count of zero is dropped and sets a sticky underflow flag. A sync that arrives while another sync is still pending is merged into the pending one.

Top module: `fence_sync_gate`

## Requirements
- R1: After reset, count_o is 0, stall_o is 0, and overflow_o and underflow_o are both 0.
- R2: A miss_sent_i pulse without reply_rcvd_i, below the maximum count, raises count_o by one at the next clock edge.
- R3: A reply_rcvd_i pulse without miss_sent_i, at a nonzero count, lowers count_o by one at the next clock edge.
- R4: When miss_sent_i and reply_rcvd_i are high in the same cycle, count_o keeps its value and neither flag changes.
- R5: The count is 5 bits wide and saturates at 31. A lone miss at 31 leaves count_o at 31 and sets overflow_o. The flag stays set until reset.
- R6: A lone reply at a count of 0 leaves count_o at 0 and sets underflow_o. The flag stays set until reset.
- R7: A sync_req_i pulse with no sync pending sets stall_o to 1 from the next clock edge.
- R8: While a sync is pending and count_o is nonzero, stall_o stays 1.
- R9: While a sync is pending and all_committed_i is 0, stall_o stays 1.
- R10: stall_o falls at the clock edge that samples a pending sync with count_o equal to 0 and all_committed_i equal to 1. It is therefore low in the cycle after both conditions are first seen true.
- R11: A sync_req_i that arrives while a sync is pending is merged into it and does not hold stall_o beyond the release in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_sent_i | input | 1 | Pulse: a lower-level miss was sent |
| reply_rcvd_i | input | 1 | Pulse: a reply to a miss returned |
| sync_req_i | input | 1 | Pulse: a sync instruction was decoded |
| all_committed_i | input | 1 | Level: all pending memory operations have committed |
| stall_o | output | 1 | Issue stall |
| count_o | output | 5 | Number of outstanding misses |
| overflow_o | output | 1 | Sticky flag: a miss arrived at the saturated count |
| underflow_o | output | 1 | Sticky flag: a reply arrived at a count of zero |

## Verification
The assertions check on every cycle that the count steps by one in the correct direction, that it holds when a miss and a reply coincide, that it saturates at both ends with the matching sticky flag, and that the stall is held while either release condition is false and drops once both are true. Only the bench scenarios can show complete sequences. These include filling the counter to 31 and past it, a sync that waits on outstanding misses and then on a late commit, and a second sync merged into a pending one.

// File: rtl/fence_pkg.sv
package fence_pkg;
  localparam int unsigned CNT_W   = 5;
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_INC  = 2'b01,
    OP_DEC  = 2'b10
  } cnt_op_e;
endpackage

// File: rtl/fence_cnt_op.sv
module fence_cnt_op
  import fence_pkg::*;
(
  input  logic    miss_i,
  input  logic    reply_i,
  output cnt_op_e op_o
);
  always_comb begin
    unique case ({reply_i, miss_i})
      2'b01:   op_o = OP_INC;
      2'b10:   op_o = OP_DEC;
      default: op_o = OP_HOLD;
    endcase
  end
endmodule

// File: rtl/fence_cnt.sv
module fence_cnt
  import fence_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  cnt_op_e op_i,
  output cnt_t    cnt_o,
  output logic    ovf_o,
  output logic    unf_o
);
  localparam cnt_t MAX_C = cnt_t'(CNT_MAX);

  cnt_t cnt_q, cnt_d;
  logic ovf_q, ovf_d, unf_q, unf_d;
  logic at_max, at_zero;

  assign at_max  = (cnt_q == MAX_C);
  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    unf_d = unf_q;
    case (op_i)
      OP_INC: if (at_max)  ovf_d = 1'b1; else cnt_d = cnt_q + cnt_t'(1);
      OP_DEC: if (at_zero) unf_d = 1'b1; else cnt_d = cnt_q - cnt_t'(1);
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  p_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INC && cnt_q != MAX_C) |=> cnt_q == cnt_t'($past(cnt_q) + cnt_t'(1)));
  p_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DEC && cnt_q != '0) |=> cnt_q == cnt_t'($past(cnt_q) - cnt_t'(1)));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD) |=> ($stable(cnt_q) && $stable(ovf_q) && $stable(unf_q)));
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INC && cnt_q == MAX_C) |=> (cnt_q == MAX_C && ovf_q));
  p_ovf_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DEC && cnt_q == '0) |=> (cnt_q == '0 && unf_q));
  p_unf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |=> unf_q);
endmodule

// File: rtl/sync_gate.sv
module sync_gate
  import fence_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic cnt_zero_i,
  input  logic committed_i,
  output logic stall_o
);
  logic pend_q, pend_d, release_ok;

  assign release_ok = cnt_zero_i && committed_i;

  // A sync seen while pending is absorbed by the pending one
  always_comb begin
    if (pend_q) pend_d = !release_ok;
    else        pend_d = sync_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign stall_o = pend_q;

  p_sync_raise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !pend_q) |=> stall_o);
  p_hold_cnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !cnt_zero_i) |=> stall_o);
  p_hold_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !committed_i) |=> stall_o);
  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cnt_zero_i && committed_i) |=> !stall_o);
  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !sync_i) |=> !stall_o);
endmodule

// File: rtl/fence_sync_gate.sv
module fence_sync_gate
  import fence_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_sent_i,
  input  logic             reply_rcvd_i,
  input  logic             sync_req_i,
  input  logic             all_committed_i,
  output logic             stall_o,
  output logic [CNT_W-1:0] count_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  cnt_op_e op;
  cnt_t    cnt;

  fence_cnt_op u_op (
    .miss_i  (miss_sent_i),
    .reply_i (reply_rcvd_i),
    .op_o    (op)
  );

  fence_cnt u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .cnt_o  (cnt),
    .ovf_o  (overflow_o),
    .unf_o  (underflow_o)
  );

  sync_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_req_i),
    .cnt_zero_i  (cnt == '0),
    .committed_i (all_committed_i),
    .stall_o     (stall_o)
  );

  assign count_o = cnt;

  p_reset_r1: assert property (@(posedge clk_i) $rose(rst_ni) |->
    (count_o == '0 && !stall_o && !overflow_o && !underflow_o));
endmodule

// File: tb/fence_sync_gate_tb_top.sv
module fence_sync_gate_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic miss = 1'b0, reply = 1'b0, sync = 1'b0, comm = 1'b1;
  logic stall, ovf, unf;
  logic [4:0] cnt;
  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  fence_sync_gate dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .miss_sent_i(miss), .reply_rcvd_i(reply),
    .sync_req_i(sync), .all_committed_i(comm), .stall_o(stall),
    .count_o(cnt), .overflow_o(ovf), .underflow_o(unf)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(logic m, logic r, logic s);
    @(negedge clk_i);
    miss = m; reply = r; sync = s;
    @(posedge clk_i); #1;
    miss = 0; reply = 0; sync = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0; comm = 1;
    @(negedge clk_i); rst_ni = 1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", cnt, 0); chk("R1 stall", stall, 0);
    chk("R1 ovf", ovf, 0);   chk("R1 unf", unf, 0);
  endtask

  task automatic t_count();
    do_reset();
    cyc(1, 0, 0); chk("R2 inc", cnt, 1);
    cyc(1, 0, 0); cyc(1, 0, 0); chk("R2 inc3", cnt, 3);
    cyc(0, 1, 0); chk("R3 dec", cnt, 2);
    cyc(1, 1, 0); chk("R4 both", cnt, 2);
    chk("R4 flags", {ovf, unf}, 0);
    cyc(0, 1, 0); cyc(0, 1, 0); chk("R3 dec to 0", cnt, 0);
    cyc(1, 1, 0); chk("R4 both at 0", cnt, 0);
    chk("R4 no unf", unf, 0);
  endtask

  task automatic t_sat();
    do_reset();
    for (int i = 0; i < 31; i++) cyc(1, 0, 0);
    chk("R5 at max", cnt, 31); chk("R5 no ovf yet", ovf, 0);
    cyc(1, 0, 0); chk("R5 saturated", cnt, 31); chk("R5 ovf set", ovf, 1);
    cyc(0, 1, 0); chk("R5 dec after sat", cnt, 30); chk("R5 ovf sticky", ovf, 1);
    do_reset();
    cyc(0, 1, 0); chk("R6 stays 0", cnt, 0); chk("R6 unf set", unf, 1);
    cyc(1, 0, 0); chk("R6 count after", cnt, 1); chk("R6 unf sticky", unf, 1);
  endtask

  task automatic t_sync_simple();
    do_reset();
    cyc(0, 0, 1); chk("R7 stall raised", stall, 1);
    cyc(0, 0, 0); chk("R10 release", stall, 0);
    cyc(0, 0, 0); chk("R10 stays low", stall, 0);
  endtask

  task automatic t_sync_wait();
    do_reset();
    cyc(1, 0, 0); cyc(1, 0, 0);
    cyc(0, 0, 1); chk("R7 stall", stall, 1);
    cyc(0, 1, 0); chk("R8 held cnt=1", stall, 1);
    @(negedge clk_i); comm = 0;
    cyc(0, 1, 0); chk("R8 held at edge count hit 0", stall, 1);
    cyc(0, 0, 0); chk("R9 held uncommitted", stall, 1);
    cyc(0, 0, 0); chk("R9 still held", stall, 1);
    @(negedge clk_i); comm = 1;
    cyc(0, 0, 0); chk("R10 release", stall, 0);
  endtask

  task automatic t_merge();
    do_reset();
    cyc(1, 0, 0);
    cyc(0, 0, 1); chk("R7 stall", stall, 1);
    cyc(0, 0, 1); chk("R11 merged held", stall, 1);
    cyc(0, 1, 1); chk("R11 held at edge count hit 0", stall, 1);
    cyc(0, 0, 0); chk("R11 release once", stall, 0);
    cyc(0, 0, 0); chk("R11 not relaunched", stall, 0);
  endtask

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_sat();
    t_sync_simple();
    t_sync_wait();
    t_merge();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule